// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line in a small direct-mapped private cache that shares a snooping bus with other caches. Each line holds a tag and one of four states: Modified, Exclusive, Shared or Invalid. The controller takes load and store requests from its own processor and decides whether each one can complete locally. If it cannot, it issues a fill, an ownership request, an invalidate or a writeback on a request/grant bus port. At the same time it watches transactions that other caches place on the bus and demotes or drops its own copies.

The local port handles one request at a time. A request that needs the bus keeps the ready output low until its bus transaction has been granted. A completion pulse reports whether the access finished without any bus traffic. Snooped transactions arrive one per cycle in bus order. When a snoop hits a Modified line, the controller signals on a flush output that it supplies the dirty data. Data arrays, arbitration between caches and the memory behind the bus are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, `bus_req` is low and no completion is pending. The first access to any address is therefore a miss.
- R2: State encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11. Bus operation codes are read=1, read-for-ownership=2, invalidate=3, writeback=4. A local read miss issues a read (code 1) for the line address with the offset bits zeroed, and installs the line in Exclusive. Its completion reports `cpu_hit`=0.
- R3: A local read of a valid line with a matching tag completes one cycle after acceptance with `cpu_hit`=1 and no bus request.
- R4: A local write to an Exclusive line completes with `cpu_hit`=1 and no bus request, and the line becomes Modified.
- R5: A snooped read to an Exclusive line makes it Shared with no flush. A snooped read to a Modified line pulses `snp_flush` one cycle later and makes it Shared.
- R6: A local write to a Shared line issues an invalidate (code 3) and completes with `cpu_hit`=0 after the grant. The line is then Modified.
- R7: A local write miss issues a read-for-ownership (code 2) and installs the line directly in Modified. Its completion reports `cpu_hit`=0.
- R8: A snooped read-for-ownership or invalidate to a Shared or Exclusive line makes it Invalid with no flush. To a Modified line, it pulses `snp_flush` and then makes the line Invalid.
- R9: A miss whose index holds a Modified line with another tag first issues a writeback (code 4) of the old line's address, and only then issues the fill for the new line.
- R10: While a bus transaction is pending, `cpu_ready` is low. `bus_req`, `bus_op` and `bus_addr` hold steady until `bus_gnt`, unless a snoop changes the pending work.
- R11: When a snoop and a local request target the same line in the same cycle, the snoop's state change is applied before the local request is decided.
- R12: If a pending invalidate's line is itself invalidated by a snoop before the grant, the request turns into a read-for-ownership for the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local request present |
| cpu_write | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Local byte address |
| cpu_ready | output | 1 | Local port can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed access needed no bus traffic |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 3 | Requested operation code |
| bus_addr | output | ADDR_W | Line address of the request |
| bus_gnt | input | 1 | Grant; transaction done in the cycle req and gnt are both high |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 3 | Snooped operation code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data for the previous snoop |

## Verification
On every cycle the assertions check the following. Ready stays low while a request is out. The request stays steady until it is granted. Each grant leaves the line in the state its operation implies: Exclusive after a read, Modified after ownership or invalidate, Invalid after a writeback. Hits and flushes appear only after an accepted request or a snoop. Only the bench's scenarios can show the protocol orderings. These are the silent Exclusive-to-Modified write, the demotions seen through later bus traffic, victim writeback before the fill, snoop-first ordering on a same-cycle collision, and the conversion of an invalidate that a snoop overtook.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RFO  = 3'd2,
    OP_INV  = 3'd3,
    OP_WB   = 3'd4
  } bus_op_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WB   = 2'd1,
    PH_ACQ  = 2'd2
  } phase_t;

  // state a line takes after another cache's transaction
  function automatic line_st_t snoop_next(input line_st_t s, input logic [2:0] op);
    if (op == OP_RD) return (s == ST_I) ? ST_I : ST_S;
    if (op == OP_RFO || op == OP_INV) return ST_I;
    return s;
  endfunction

  // dirty data must be supplied when a snoop touches a Modified line
  function automatic logic snoop_flush(input line_st_t s, input logic [2:0] op);
    return (s == ST_M) && (op == OP_RD || op == OP_RFO || op == OP_INV);
  endfunction

  // a local access completes without the bus
  function automatic logic local_hit(input line_st_t s, input logic wr);
    return wr ? (s == ST_E || s == ST_M) : (s != ST_I);
  endfunction

  // state installed when a fill is granted
  function automatic line_st_t fill_state(input logic [2:0] op);
    return (op == OP_RD) ? ST_E : ST_M;
  endfunction

endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic             snp_valid,
  input  logic [2:0]       snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             hit,
  output line_st_t         nxt_st,
  output logic             flush
);
  logic op_ok;

  always_comb begin
    op_ok  = (snp_op == OP_RD) || (snp_op == OP_RFO) || (snp_op == OP_INV);
    hit    = snp_valid && op_ok && (line_tag == snp_tag) && (line_st != ST_I);
    nxt_st = snoop_next(line_st, snp_op);
    flush  = hit && snoop_flush(line_st, snp_op);
  end
endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup port
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output line_st_t         lk_st,
  // snoop port
  input  logic [IDX_W-1:0] sn_idx,
  output logic [TAG_W-1:0] sn_tag,
  output line_st_t         sn_st,
  // observation port
  input  logic [IDX_W-1:0] ob_idx,
  output line_st_t         ob_st,
  // snoop write
  input  logic             sn_we,
  input  line_st_t         sn_wst,
  // local write (wins over snoop, it was decided on the post-snoop state)
  input  logic [IDX_W-1:0] loc_idx,
  input  logic             loc_st_we,
  input  line_st_t         loc_wst,
  input  logic             loc_tag_we,
  input  logic [TAG_W-1:0] loc_wtag
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else begin
        if (loc_st_we && loc_idx == MY_IDX)  st_q[g] <= loc_wst;
        else if (sn_we && sn_idx == MY_IDX)  st_q[g] <= sn_wst;
        if (loc_tag_we && loc_idx == MY_IDX) tag_q[g] <= loc_wtag;
      end
    end
  end

  assign lk_tag = tag_q[lk_idx];
  assign lk_st  = st_q[lk_idx];
  assign sn_tag = tag_q[sn_idx];
  assign sn_st  = st_q[sn_idx];
  assign ob_st  = st_q[ob_idx];
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic [2:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [2:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  phase_t           phase;
  bus_op_t          pend_op;
  logic [IDX_W-1:0] pend_idx;
  logic [TAG_W-1:0] pend_tag;
  logic             done_q, hit_q, flush_q;

  // address split
  logic [IDX_W-1:0] cpu_idx, sn_idx, lk_idx;
  logic [TAG_W-1:0] cpu_tag, sn_tag_in;
  assign cpu_idx   = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign sn_idx    = snp_addr[OFF_W +: IDX_W];
  assign sn_tag_in = snp_addr[ADDR_W-1 -: TAG_W];
  assign lk_idx    = (phase == PH_IDLE) ? cpu_idx : pend_idx;

  // storage
  logic [TAG_W-1:0] lk_tag, sn_tag;
  line_st_t         lk_st_raw, sn_st, pend_st, sn_next, loc_wst;
  logic             sn_hit, sn_flush, loc_st_we, loc_tag_we;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (lk_idx),
    .lk_tag     (lk_tag),
    .lk_st      (lk_st_raw),
    .sn_idx     (sn_idx),
    .sn_tag     (sn_tag),
    .sn_st      (sn_st),
    .ob_idx     (pend_idx),
    .ob_st      (pend_st),
    .sn_we      (sn_hit),
    .sn_wst     (sn_next),
    .loc_idx    (lk_idx),
    .loc_st_we  (loc_st_we),
    .loc_wst    (loc_wst),
    .loc_tag_we (loc_tag_we),
    .loc_wtag   (pend_tag)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_op    (snp_op),
    .snp_tag   (sn_tag_in),
    .line_tag  (sn_tag),
    .line_st   (sn_st),
    .hit       (sn_hit),
    .nxt_st    (sn_next),
    .flush     (sn_flush)
  );

  // snoop is applied first: local decisions see the post-snoop state
  line_st_t lk_st;
  assign lk_st = (sn_hit && sn_idx == lk_idx) ? sn_next : lk_st_raw;

  // named events
  logic accept, tag_match, ev_hit, ev_upgrade, ev_miss, ev_victim_wb, bus_fire;
  assign accept       = cpu_valid && (phase == PH_IDLE);
  assign tag_match    = (lk_tag == cpu_tag);
  assign ev_hit       = accept && tag_match && local_hit(lk_st, cpu_write);
  assign ev_upgrade   = accept && tag_match && cpu_write && (lk_st == ST_S);
  assign ev_miss      = accept && !ev_hit && !ev_upgrade;
  assign ev_victim_wb = ev_miss && (lk_st == ST_M);
  assign bus_fire     = bus_req && bus_gnt;

  // bus request
  always_comb begin
    bus_req  = (phase == PH_ACQ) || (phase == PH_WB && lk_st == ST_M);
    bus_op   = (phase == PH_WB) ? OP_WB : pend_op;
    bus_addr = (phase == PH_WB) ? {lk_tag, pend_idx, {OFF_W{1'b0}}}
                                : {pend_tag, pend_idx, {OFF_W{1'b0}}};
  end

  // local state writes
  always_comb begin
    loc_st_we  = 1'b0;
    loc_wst    = ST_I;
    loc_tag_we = 1'b0;
    if (ev_hit && cpu_write) begin
      loc_st_we = 1'b1;
      loc_wst   = ST_M;
    end else if (phase == PH_WB && bus_fire) begin
      loc_st_we = 1'b1;
      loc_wst   = ST_I;
    end else if (phase == PH_ACQ && bus_fire) begin
      loc_st_we  = 1'b1;
      loc_wst    = fill_state(pend_op);
      loc_tag_we = 1'b1;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pend_op  <= OP_NONE;
      pend_idx <= '0;
      pend_tag <= '0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      flush_q <= sn_flush;
      case (phase)
        PH_IDLE: begin
          if (ev_hit) begin
            done_q <= 1'b1;
            hit_q  <= 1'b1;
          end else if (ev_upgrade || ev_miss) begin
            pend_idx <= cpu_idx;
            pend_tag <= cpu_tag;
            pend_op  <= ev_upgrade ? OP_INV : (cpu_write ? OP_RFO : OP_RD);
            phase    <= ev_victim_wb ? PH_WB : PH_ACQ;
          end
        end
        PH_WB: begin
          if (bus_fire || lk_st != ST_M) phase <= PH_ACQ;
        end
        PH_ACQ: begin
          if (bus_fire) begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end else if (pend_op == OP_INV && lk_st == ST_I) begin
            pend_op <= OP_RFO;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cpu_ready = (phase == PH_IDLE);
  assign cpu_done  = done_q;
  assign cpu_hit   = hit_q;
  assign snp_flush = flush_q;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              bus_req,
  input logic [2:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              bus_fire,
  input logic              snp_valid,
  input logic [2:0]        snp_op,
  input logic              snp_flush,
  input line_st_t          pend_st
);
  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

  assert_read_fill_e_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_op == OP_RD) |=> (pend_st == ST_E));

  assert_own_fill_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_op == OP_RFO) |=> (pend_st == ST_M));

  assert_upgrade_m_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_op == OP_INV) |=> (pend_st == ST_M));

  assert_victim_gone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fire && bus_op == OP_WB) |=> (pend_st == ST_I && bus_req && bus_op != OP_WB));

  assert_hit_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_hit) |-> $past(cpu_valid && cpu_ready));

  assert_miss_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !cpu_hit) |-> $past(bus_fire));

  assert_flush_after_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(snp_valid && snp_op != OP_NONE));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .cpu_done  (cpu_done),
  .cpu_hit   (cpu_hit),
  .bus_req   (bus_req),
  .bus_op    (bus_op),
  .bus_addr  (bus_addr),
  .bus_gnt   (bus_gnt),
  .bus_fire  (bus_fire),
  .snp_valid (snp_valid),
  .snp_op    (snp_op),
  .snp_flush (snp_flush),
  .pend_st   (pend_st)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
  localparam int AW = 16;
  localparam logic [2:0] C_RD = 3'd1, C_RFO = 3'd2, C_INV = 3'd3, C_WB = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_ready, cpu_done, cpu_hit, bus_req, snp_flush;
  logic [2:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0;
  logic snp_valid = 1'b0;
  logic [2:0] snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic hold_gnt = 1'b0;

  int errors = 0, checks = 0, cycles = 0, wcnt = 0;

  bit    exp_hit_q [$];
  string exp_hit_req [$];
  logic [18:0] exp_bus_q [$];
  string exp_bus_req [$];

  mesi_line_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .snp_flush(snp_flush)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return {10'(tag), 4'(idx), 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rst_n && cpu_done) begin
      if (exp_hit_q.size() == 0) check(0, "R3", "unexpected completion", cpu_hit, 0);
      else begin
        automatic bit e = exp_hit_q.pop_front();
        automatic string r = exp_hit_req.pop_front();
        check(cpu_hit == e, r, "cpu_hit", cpu_hit, e);
      end
    end
  end

  // bus model: grant after a short wait, compare against the expectation queue
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; wcnt <= 0;
    end else if (bus_gnt) begin
      bus_gnt <= 1'b0; wcnt <= 0;
    end else if (bus_req && !hold_gnt) begin
      if (wcnt == 2) begin
        check(!cpu_ready, "R10", "ready during bus request", cpu_ready, 0);
        if (exp_bus_q.size() == 0)
          check(0, "R3", "unexpected bus request", {bus_op, bus_addr}, 0);
        else begin
          automatic logic [18:0] e = exp_bus_q.pop_front();
          automatic string r = exp_bus_req.pop_front();
          check({bus_op, bus_addr} == e, r, "bus op/addr", {bus_op, bus_addr}, e);
        end
        bus_gnt <= 1'b1;
      end else wcnt <= wcnt + 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(0, "R10", "watchdog expired", cycles, 20000);
      summary();
    end
  end

  task automatic expect_bus(input logic [2:0] op, input logic [AW-1:0] a, input string req);
    exp_bus_q.push_back({op, a});
    exp_bus_req.push_back(req);
  endtask

  task automatic wait_done();
    while (exp_hit_q.size() != 0) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input bit eh, input string req);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    exp_hit_q.push_back(eh); exp_hit_req.push_back(req);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
    @(negedge clk);
    cpu_valid = 1'b0;
    wait_done();
  endtask

  task automatic snoop(input logic [2:0] op, input logic [AW-1:0] a, input bit ef, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    check(snp_flush == ef, req, "snp_flush", snp_flush, ef);
  endtask

  // local request and snoop presented in the same cycle
  task automatic collide(input bit wr, input logic [AW-1:0] a, input bit eh,
                         input logic [2:0] op, input bit ef, input string req);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    exp_hit_q.push_back(eh); exp_hit_req.push_back(req);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    cpu_valid = 1'b0; snp_valid = 1'b0;
    check(snp_flush == ef, req, "snp_flush on collision", snp_flush, ef);
    wait_done();
  endtask

  initial begin
    logic [AW-1:0] a_addr, b_addr, c_addr, d_addr;
    a_addr = mk(1, 1); b_addr = mk(2, 1); c_addr = mk(3, 2); d_addr = mk(7, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R1", "ready after reset", cpu_ready, 1);
    check(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
    check(cpu_done == 1'b0, "R1", "done after reset", cpu_done, 0);

    // R1/R2: first read misses, fills Exclusive
    expect_bus(C_RD, a_addr, "R2");
    access(0, a_addr | 16'h3, 0, "R1");
    access(0, a_addr, 1, "R3");
    // R4: silent write to Exclusive, becomes Modified (visible as flush)
    access(1, a_addr, 1, "R4");
    snoop(C_RD, a_addr, 1, "R5");
    // now Shared: write needs invalidate
    expect_bus(C_INV, a_addr, "R6");
    access(1, a_addr, 0, "R6");
    access(0, a_addr, 1, "R6");
    // R8: ownership snoop on Modified flushes, then line is Invalid
    snoop(C_RFO, a_addr, 1, "R8");
    expect_bus(C_RD, a_addr, "R8");
    access(0, a_addr, 0, "R8");
    // R5: snooped read on Exclusive, no flush, becomes Shared
    snoop(C_RD, a_addr, 0, "R5");
    expect_bus(C_INV, a_addr, "R5");
    access(1, a_addr, 0, "R5");
    // R9/R7: conflicting write miss with Modified victim
    expect_bus(C_WB, a_addr, "R9");
    expect_bus(C_RFO, b_addr, "R7");
    access(1, b_addr, 0, "R9");
    access(0, b_addr, 1, "R7");
    access(1, b_addr, 1, "R7");
    // old line really gone
    snoop(C_RD, a_addr, 0, "R9");
    // R8: invalidate on Modified
    snoop(C_INV, b_addr, 1, "R8");
    expect_bus(C_RD, b_addr, "R8");
    access(0, b_addr, 0, "R8");
    // R8: ownership snoop on Exclusive, no flush
    expect_bus(C_RD, c_addr, "R2");
    access(0, c_addr, 0, "R2");
    snoop(C_RFO, c_addr, 0, "R8");
    expect_bus(C_RD, c_addr, "R8");
    access(0, c_addr, 0, "R8");
    // R11: snooped read and local write collide on Exclusive line
    expect_bus(C_INV, c_addr, "R11");
    collide(1, c_addr, 0, C_RD, 0, "R11");
    // Modified -> Shared by snooped read
    snoop(C_RD, c_addr, 1, "R5");
    // R11: invalidate collides with local read on Shared line
    expect_bus(C_RD, c_addr, "R11");
    collide(0, c_addr, 0, C_INV, 0, "R11");
    // R12: pending invalidate overtaken by ownership snoop
    expect_bus(C_RD, d_addr, "R12");
    access(0, d_addr, 0, "R12");
    snoop(C_RD, d_addr, 0, "R12");
    hold_gnt = 1'b1;
    expect_bus(C_RFO, d_addr, "R12");
    fork
      access(1, d_addr, 0, "R12");
      begin
        @(negedge clk);
        while (!bus_req) @(negedge clk);
        check(bus_op == C_INV, "R12", "op before snoop", bus_op, C_INV);
        snoop(C_RFO, d_addr, 0, "R12");
        check(bus_req && bus_op == C_RFO, "R12", "op after snoop", bus_op, C_RFO);
        hold_gnt = 1'b0;
      end
    join
    access(0, d_addr, 1, "R12");
    repeat (4) @(negedge clk);
    check(exp_bus_q.size() == 0, "R10", "unserved bus expectations", exp_bus_q.size(), 0);
    check(bus_req == 1'b0 && cpu_ready, "R10", "idle at end", bus_req, 0);
    summary();
  end
endmodule